// File: doc/BRIEF.md
# Trap Target Privilege Resolver

This block decides which privilege level takes a trap. It looks at the mode the hart is running in, whether the trap is an interrupt or an exception, and the cause code. It then reads the matching delegation bit from the machine-level and supervisor-level delegation registers. The result is also shaped by two inputs that say whether supervisor mode and user-level trap handling are implemented. When supervisor mode is absent, a trap delegated by machine mode drops to user mode if user-level traps exist, and otherwise stays in machine mode.

The decision itself is purely combinational and appears on `target_comb_o`. A copy is captured into `target_q_o` on each cycle where `trap_valid_i` is high, so the trap-entry logic further down the pipe can use a stable registered value.

Privilege encoding used on every mode port: user = 2'b00, supervisor = 2'b01, machine = 2'b11. The value 2'b10 is reserved. As a current mode it counts as "below machine" and "not user".

Top module: `trap_target_resolver`

## Requirements
- R1: With no applicable delegation bit set, the target is machine mode (2'b11).
- R2: Interrupts (`is_irq_i`=1) use only the two interrupt-delegation inputs. Exceptions use only the two exception-delegation inputs. The other pair has no effect on the target.
- R3: When the current mode is machine (2'b11), the target is machine regardless of any delegation bit.
- R4: When the current mode is below machine, the machine delegation bit at index `cause_i` is set, and supervisor mode is implemented, the first-level target is supervisor (2'b01).
- R5: Under the conditions of R4 but with supervisor mode absent and user-level traps implemented, the first-level target is user (2'b00).
- R6: Under the conditions of R4 with neither supervisor mode nor user-level traps implemented, the target stays machine.
- R7: When the current mode is user (2'b00), both supervisor mode and user-level traps are implemented, and the supervisor delegation bit at index `cause_i` is set, the target is user. This overrides the first-level result, even when the machine bit is clear.
- R8: If either optional level is absent, the supervisor delegation bit has no effect.
- R9: The delegation bit used is bit `cause_i` (0 to 63) of the 64-bit register. No other bit affects the result.
- R10: `target_q_o` resets to machine under synchronous active-low reset. On a clock edge with `trap_valid_i` high it takes the combinational target. On any other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| trap_valid_i | input | 1 | Capture strobe for the registered target |
| cur_priv_i | input | 2 | Current privilege mode |
| is_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| cause_i | input | 6 | Trap cause code, the bit index into delegation registers |
| m_ideleg_i | input | 64 | Machine-level interrupt delegation |
| m_edeleg_i | input | 64 | Machine-level exception delegation |
| s_ideleg_i | input | 64 | Supervisor-level interrupt delegation |
| s_edeleg_i | input | 64 | Supervisor-level exception delegation |
| has_smode_i | input | 1 | Supervisor mode implemented |
| has_utrap_i | input | 1 | User-level trap handling implemented |
| target_comb_o | output | 2 | Combinational target privilege |
| target_q_o | output | 2 | Target captured on `trap_valid_i` |

## Verification
The hardest case to reach is a single cause bit that is set in one register while every other bit, and the same bit in the opposite trap class, holds the contrary value. Only in that case does a wrong index or a swapped register pair show at the output. The exhaustive sweep meets this by building every register from the cause under test. The selected bit gets the value wanted, and every other bit and the other class's registers get its complement. The cause index also moves through the 64 positions as the sweep goes on. The second-level override with the machine bit clear is also rare under random traffic, so the sweep includes it in every mode and extension combination.

// File: rtl/trap_priv_pkg.sv
// Shared privilege encoding for the trap target resolver.
package trap_priv_pkg;
    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;
endpackage

// File: rtl/trap_deleg_pick.sv
// Picks the machine and supervisor delegation bits for one trap.
// Assumes: cause is a plain bit index; the interrupt flag chooses the
// register pair. Built as decoded one-hot AND-OR so depth is log2(width).
module trap_deleg_pick #(
    parameter int CAUSE_W = 6,
    localparam int DELEG_W = 1 << CAUSE_W
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [DELEG_W-1:0] m_ideleg,
    input  logic [DELEG_W-1:0] m_edeleg,
    input  logic [DELEG_W-1:0] s_ideleg,
    input  logic [DELEG_W-1:0] s_edeleg,
    output logic               m_bit,
    output logic               s_bit
);
    logic [DELEG_W-1:0] m_sel, s_sel, dec, m_hit, s_hit;

    // Pick the register pair that matches the trap class.
    always_comb begin
        m_sel = is_irq ? m_ideleg : m_edeleg;
        s_sel = is_irq ? s_ideleg : s_edeleg;
    end

    // One-hot decode of the cause gated onto each register bit.
    for (genvar gi = 0; gi < DELEG_W; gi++) begin : g_bit
        assign dec[gi]   = (cause == CAUSE_W'(gi));
        assign m_hit[gi] = m_sel[gi] & dec[gi];
        assign s_hit[gi] = s_sel[gi] & dec[gi];
    end

    assign m_bit = |m_hit;
    assign s_bit = |s_hit;

    // R9: decode is one-hot for every cause value.
    always_comb begin
        a_r9_onehot_decode: assert ($onehot(dec) || $isunknown(cause));
    end
endmodule

// File: rtl/trap_lvl1_resolve.sv
// First-level decision from the machine delegation bit.
// Assumes: anything other than machine counts as below machine; falls back
// supervisor -> user -> machine by which optional levels exist.
module trap_lvl1_resolve
    import trap_priv_pkg::*;
(
    input  priv_e cur_priv,
    input  logic  m_bit,
    input  logic  has_smode,
    input  logic  has_utrap,
    output priv_e first_tgt
);
    // Choose the first-level target with the fallback chain.
    always_comb begin
        first_tgt = PRIV_M;
        if (cur_priv != PRIV_M && m_bit) begin
            if (has_smode)      first_tgt = PRIV_S;
            else if (has_utrap) first_tgt = PRIV_U;
            else                first_tgt = PRIV_M;
        end
    end
endmodule

// File: rtl/trap_lvl2_resolve.sv
// Second-level override from the supervisor delegation bit.
// Assumes: only applies from user mode with both optional levels present.
module trap_lvl2_resolve
    import trap_priv_pkg::*;
(
    input  priv_e cur_priv,
    input  logic  s_bit,
    input  logic  has_smode,
    input  logic  has_utrap,
    input  priv_e first_tgt,
    output priv_e final_tgt
);
    logic take_user;

    // Decide whether the override fires.
    always_comb take_user = (cur_priv == PRIV_U) && has_smode && has_utrap && s_bit;

    // Apply the override on top of the first-level result.
    always_comb final_tgt = take_user ? PRIV_U : first_tgt;
endmodule

// File: rtl/trap_target_resolver.sv
// Top: resolves trap target privilege and captures it on a trap strobe.
// Assumes: all inputs are stable around the capturing edge; synchronous
// active-low reset puts the captured target at machine mode.
module trap_target_resolver
    import trap_priv_pkg::*;
#(
    parameter int CAUSE_W = 6,
    localparam int DELEG_W = 1 << CAUSE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trap_valid_i,
    input  logic [1:0]         cur_priv_i,
    input  logic               is_irq_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [DELEG_W-1:0] m_ideleg_i,
    input  logic [DELEG_W-1:0] m_edeleg_i,
    input  logic [DELEG_W-1:0] s_ideleg_i,
    input  logic [DELEG_W-1:0] s_edeleg_i,
    input  logic               has_smode_i,
    input  logic               has_utrap_i,
    output logic [1:0]         target_comb_o,
    output logic [1:0]         target_q_o
);
    priv_e cur_priv, first_tgt, final_tgt, tgt_q;
    logic  m_bit, s_bit;

    assign cur_priv = priv_e'(cur_priv_i);

    trap_deleg_pick #(.CAUSE_W(CAUSE_W)) u_pick (
        .is_irq   (is_irq_i),
        .cause    (cause_i),
        .m_ideleg (m_ideleg_i),
        .m_edeleg (m_edeleg_i),
        .s_ideleg (s_ideleg_i),
        .s_edeleg (s_edeleg_i),
        .m_bit    (m_bit),
        .s_bit    (s_bit)
    );

    trap_lvl1_resolve u_lvl1 (
        .cur_priv  (cur_priv),
        .m_bit     (m_bit),
        .has_smode (has_smode_i),
        .has_utrap (has_utrap_i),
        .first_tgt (first_tgt)
    );

    trap_lvl2_resolve u_lvl2 (
        .cur_priv  (cur_priv),
        .s_bit     (s_bit),
        .has_smode (has_smode_i),
        .has_utrap (has_utrap_i),
        .first_tgt (first_tgt),
        .final_tgt (final_tgt)
    );

    // Capture the resolved target on the trap strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)           tgt_q <= PRIV_M;
        else if (trap_valid_i) tgt_q <= final_tgt;
    end

    assign target_comb_o = final_tgt;
    assign target_q_o    = tgt_q;

    // R3: machine mode never hands a trap downward.
    a_r3_machine_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_priv_i == 2'b11) |-> (target_comb_o == 2'b11));
    // R4: a supervisor target needs supervisor mode present.
    a_r4_smode_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (target_comb_o == 2'b01) |-> has_smode_i);
    // R5/R7: a user target needs user-level traps present.
    a_r5_utrap_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (target_comb_o == 2'b00) |-> has_utrap_i);
    // R6: reserved encoding never produced.
    a_r6_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        target_comb_o != 2'b10);
    // R10: capture on strobe.
    a_r10_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_valid_i |=> (target_q_o == $past(target_comb_o)));
    // R10: hold without strobe.
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_valid_i && $past(rst_ni)) |=> $stable(target_q_o));
endmodule

// File: tb/trap_target_resolver_tb.sv
`timescale 1ns/1ps
module trap_target_resolver_tb;
    localparam int CW = 6;
    localparam int DW = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tv = 1'b0;
    logic [1:0]    cur = 2'b11;
    logic          irq = 1'b0;
    logic [CW-1:0] cause = '0;
    logic [DW-1:0] mi = '0, me = '0, si = '0, se = '0;
    logic          hs = 1'b0, hu = 1'b0;
    logic [1:0]    tc, tq;
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    trap_target_resolver #(.CAUSE_W(CW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .cur_priv_i(cur),
        .is_irq_i(irq), .cause_i(cause), .m_ideleg_i(mi), .m_edeleg_i(me),
        .s_ideleg_i(si), .s_edeleg_i(se), .has_smode_i(hs), .has_utrap_i(hu),
        .target_comb_o(tc), .target_q_o(tq)
    );

    // Expected target straight from the requirements.
    function automatic logic [1:0] ref_tgt(input logic [1:0] c, input logic s,
                                           input logic u, input logic mb, input logic sb);
        logic [1:0] t;
        t = 2'b11;
        if (c != 2'b11 && mb) t = s ? 2'b01 : (u ? 2'b00 : 2'b11);
        if (c == 2'b00 && s && u && sb) t = 2'b00;
        return t;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one case: the selected bit takes mb/sb, all other bits and the
    // other class's registers take the complement (R2, R9).
    task automatic drive(input logic [1:0] c, input logic i, input logic [CW-1:0] cz,
                         input logic s, input logic u, input logic mb, input logic sb);
        logic [DW-1:0] one, mv, sv;
        one = DW'(1) << cz;
        mv = mb ? one : ~one;
        sv = sb ? one : ~one;
        cur = c; irq = i; cause = cz; hs = s; hu = u;
        if (i) begin mi = mv; si = sv; me = ~mv; se = ~sv; end
        else   begin me = mv; se = sv; mi = ~mv; si = ~sv; end
    endtask

    // Directed vectors: {cur[1:0], irq, smode, utrap, mbit, sbit, exp[1:0]}.
    localparam logic [8:0] VEC [12] = '{
        {2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11},  // R1
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11},  // R3
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01},  // R4
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01},  // R4/R8
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00},  // R5
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00},  // R5
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11},  // R6
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01},  // R4 reserved mode
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00},  // R7 override
        {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00},  // R7
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11},  // R8 not user
        {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11}   // R8 no smode
    };

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset value of captured target.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", tq, 2'b11);
        rst_n = 1'b1;

        // Directed table.
        for (int k = 0; k < 12; k++) begin
            drive(VEC[k][8:7], VEC[k][6], CW'(k * 5 + 3), VEC[k][5], VEC[k][4],
                  VEC[k][3], VEC[k][2]);
            #1;
            check($sformatf("R1-8 vector %0d", k), tc, VEC[k][1:0]);
        end

        // Exhaustive sweep, cause index walking (R1..R9).
        for (int n = 0; n < 128; n++) begin
            logic [1:0] c;
            logic i, s, u, mb, sb;
            {c, i, s, u, mb, sb} = 7'(n);
            drive(c, i, CW'((n * 13 + 5) % DW), s, u, mb, sb);
            #1;
            check($sformatf("R9 sweep %0d", n), tc, ref_tgt(c, s, u, mb, sb));
        end

        // R9: top and bottom cause indices.
        drive(2'b01, 1'b1, CW'(DW - 1), 1'b1, 1'b0, 1'b1, 1'b0);
        #1; check("R9 cause max", tc, 2'b01);
        drive(2'b01, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        #1; check("R9 cause zero", tc, 2'b11);

        // R10: capture and hold.
        @(negedge clk);
        drive(2'b01, 1'b1, 6'd7, 1'b1, 1'b1, 1'b1, 1'b0);
        tv = 1'b1;
        @(negedge clk);
        check("R10 capture", tq, 2'b01);
        tv = 1'b0;
        drive(2'b00, 1'b0, 6'd9, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check("R10 hold", tq, 2'b01);
        tv = 1'b1;
        @(negedge clk);
        check("R10 second capture", tq, 2'b00);
        tv = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset again", tq, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule